// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block holds the condition state of a small 32-bit core with sixteen general registers. A compare operation presents two register values. On the next clock edge the block records five independent relation flags: equal, signed less, signed greater, unsigned less and unsigned greater. These flags are not arithmetic flags. A compound branch condition is formed by OR-ing two of them, with no carry or overflow logic.

The branch side is combinational. It takes a 16-bit instruction word and the address of that word. When the two top bits of the word are both set, it reads a 4-bit condition and a 10-bit signed word offset and evaluates the condition against the flags currently held. It then reports whether the branch is taken, the next instruction address, and whether the condition code is one of the six unassigned codes. Register file access, instruction fetch and hazard handling belong to the surrounding core.

Top module: `cmp_branch_unit`

## Requirements
- R1: After reset all five flags read as zero on `flags_o`. The bit order is bit 0 equal, bit 1 signed less, bit 2 signed greater, bit 3 unsigned less, bit 4 unsigned greater.
- R2: The clock edge that samples `cmp_valid_i` high sets the equal flag exactly when the two operands match bit for bit.
- R3: On that same edge, the signed-less and signed-greater flags are set from a two's-complement comparison of the operands. At most one of equal, signed less and signed greater is ever set.
- R4: On that same edge, the unsigned-less and unsigned-greater flags are set from an unsigned comparison. At most one of equal, unsigned less and unsigned greater is ever set.
- R5: An edge with `cmp_valid_i` low leaves all five flags unchanged, whatever the operand inputs carry.
- R6: A word is a branch only when `br_valid_i` is high and bits 15 and 14 are both 1. For any other word, `br_taken_o` and `br_illegal_o` are 0 and `br_next_o` is the address plus 2.
- R7: The condition sits in bits 13:10. Codes 0 to 9 test, in this order: equal; not equal; signed less; signed greater; unsigned less; unsigned greater; signed greater or equal; signed less or equal; unsigned greater or equal; unsigned less or equal.
- R8: Condition codes 10 to 15 raise `br_illegal_o` and are never taken.
- R9: A taken branch sets `br_next_o` to the branch's own address plus bits 9:0, sign-extended from 10 bits and multiplied by 2. Offset 0x1FF gives +1022 and offset 0x200 gives -1024. The addition wraps modulo 2^32.
- R10: A branch that is not taken sets `br_next_o` to the address plus 2, wrapping modulo 2^32.
- R11: When a compare and a branch are presented in the same cycle, the branch is evaluated against the flags held before that compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid_i | input | 1 | Compare request; the flags load on this edge |
| cmp_lhs_i | input | 32 | First compare operand |
| cmp_rhs_i | input | 32 | Second compare operand |
| br_valid_i | input | 1 | Branch word is present |
| br_insn_i | input | 16 | Instruction word |
| br_addr_i | input | 32 | Address of the instruction word |
| flags_o | output | 5 | Held relation flags |
| br_taken_o | output | 1 | Branch is taken |
| br_next_o | output | 32 | Next instruction address |
| br_illegal_o | output | 1 | Unassigned condition code |

## Verification
The compare path is tried first with every ordered pair of the four boundary values 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. These pairs are where signed and unsigned order disagree, so they separate a correct signed comparison from one that ignores the sign bit. The compare path then gets random operand pairs, including pairs that are equal. After each compare, the bench sweeps all sixteen condition codes, which separates the individual OR-combinations and the unassigned codes. Offsets at the extremes (+1022, -1024, -2, 0), an address that wraps, words that are not branches, idle cycles with changing operands, and a branch issued together with a compare cover address arithmetic, decode, flag hold and which flags a branch sees.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

   localparam int unsigned REL_FLAG_N  = 5;
   localparam int unsigned COND_W      = 4;
   localparam int unsigned COND_LEGAL  = 10;

   // bit 0 eq, 1 lt, 2 gt, 3 ltu, 4 gtu
   typedef struct packed {
      logic gtu;
      logic ltu;
      logic gt;
      logic lt;
      logic eq;
   } rel_flags_t;

   typedef enum logic [COND_W-1:0] {
      CND_EQ  = 4'd0,
      CND_NE  = 4'd1,
      CND_LT  = 4'd2,
      CND_GT  = 4'd3,
      CND_LTU = 4'd4,
      CND_GTU = 4'd5,
      CND_GE  = 4'd6,
      CND_LE  = 4'd7,
      CND_GEU = 4'd8,
      CND_LEU = 4'd9
   } cond_e;

   function automatic logic cond_holds(input logic [COND_W-1:0] code,
                                       input rel_flags_t f);
      logic r;
      case (code)
         CND_EQ:  r = f.eq;
         CND_NE:  r = !f.eq;
         CND_LT:  r = f.lt;
         CND_GT:  r = f.gt;
         CND_LTU: r = f.ltu;
         CND_GTU: r = f.gtu;
         CND_GE:  r = f.gt  | f.eq;
         CND_LE:  r = f.lt  | f.eq;
         CND_GEU: r = f.gtu | f.eq;
         CND_LEU: r = f.ltu | f.eq;
         default: r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cbu_relation.sv
module cbu_relation
   import cbu_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter bit          USE_SUB_CMP = 1'b1
) (
   input  logic [DATA_W-1:0] lhs_i,
   input  logic [DATA_W-1:0] rhs_i,
   output rel_flags_t        rel_o
);
   localparam int unsigned MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("cbu_relation: DATA_W must be at least 2");
      end

      if (USE_SUB_CMP) begin : g_sub
         // one borrow chain feeds both orders
         logic [DATA_W:0] diff;
         logic            borrow;
         logic            same_sign;
         always_comb begin
            diff      = {1'b0, lhs_i} - {1'b0, rhs_i};
            borrow    = diff[DATA_W];
            same_sign = (lhs_i[MSB] == rhs_i[MSB]);
            rel_o.eq  = (diff[MSB:0] == '0);
            rel_o.ltu = borrow;
            rel_o.gtu = !borrow && !rel_o.eq;
            rel_o.lt  = same_sign ? borrow : lhs_i[MSB];
            rel_o.gt  = !rel_o.lt && !rel_o.eq;
         end
      end else begin : g_native
         always_comb begin
            rel_o.eq  = (lhs_i == rhs_i);
            rel_o.ltu = (lhs_i < rhs_i);
            rel_o.gtu = (lhs_i > rhs_i);
            rel_o.lt  = ($signed(lhs_i) < $signed(rhs_i));
            rel_o.gt  = ($signed(lhs_i) > $signed(rhs_i));
         end
      end
   endgenerate

endmodule

// File: rtl/cbu_flag_reg.sv
module cbu_flag_reg
   import cbu_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  rel_flags_t        rel_i,
   input  logic [DATA_W-1:0] lhs_i,
   input  logic [DATA_W-1:0] rhs_i,
   output rel_flags_t        flags_o
);
   localparam int unsigned MSB = DATA_W - 1;

   rel_flags_t flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (load_i) begin
         flags_q <= rel_i;
      end
   end

   assign flags_o = flags_q;

   // R5
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(flags_q));

   // R2
   eq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (flags_q.eq == ($past(lhs_i) == $past(rhs_i))));

   // R3
   signed_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flags_q.eq, flags_q.lt, flags_q.gt}));

   // R4
   unsigned_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flags_q.eq, flags_q.ltu, flags_q.gtu}));

   // R3 R4: equal signs make both orders agree
   order_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && (lhs_i[MSB] == rhs_i[MSB])) |=> (flags_q.lt == flags_q.ltu));

endmodule

// File: rtl/cbu_branch_eval.sv
module cbu_branch_eval
   import cbu_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned INSN_W = 16,
   parameter int unsigned OFS_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [INSN_W-1:0] insn_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  rel_flags_t        flags_i,
   output logic              taken_o,
   output logic [ADDR_W-1:0] next_o,
   output logic              illegal_o
);
   localparam int unsigned COND_LSB  = OFS_W;
   localparam int unsigned COND_MSB  = OFS_W + COND_W - 1;
   localparam int unsigned FORM_HI   = INSN_W - 1;
   localparam int unsigned FORM_LO   = INSN_W - 2;
   localparam int unsigned EXT_W     = ADDR_W - OFS_W - 1;
   localparam int unsigned INSN_STEP = INSN_W / 8;

   generate
      if (COND_MSB >= FORM_LO) begin : g_bad_fields
         $error("cbu_branch_eval: condition and offset overlap the form bits");
      end
      if (ADDR_W <= OFS_W + 1) begin : g_bad_addr
         $error("cbu_branch_eval: ADDR_W too small for the scaled offset");
      end
   endgenerate

   logic              is_branch;
   logic [COND_W-1:0] code;
   logic              legal;
   logic [ADDR_W-1:0] disp;
   logic [ADDR_W-1:0] seq_addr;
   logic [ADDR_W-1:0] tgt_addr;

   always_comb begin
      is_branch = valid_i && insn_i[FORM_HI] && insn_i[FORM_LO];
      code      = insn_i[COND_MSB:COND_LSB];
      legal     = (code < COND_W'(COND_LEGAL));
      disp      = {{EXT_W{insn_i[OFS_W-1]}}, insn_i[OFS_W-1:0], 1'b0};
      seq_addr  = addr_i + ADDR_W'(INSN_STEP);
      tgt_addr  = addr_i + disp;
      taken_o   = is_branch && legal && cond_holds(code, flags_i);
      illegal_o = is_branch && !legal;
      next_o    = taken_o ? tgt_addr : seq_addr;
   end

   // R8
   illegal_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> !taken_o);

   // R10
   fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !taken_o |-> (next_o == addr_i + ADDR_W'(INSN_STEP)));

   // R6
   non_branch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_i && insn_i[FORM_HI] && insn_i[FORM_LO]) |-> (!taken_o && !illegal_o));

endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
   import cbu_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned INSN_W      = 16,
   parameter int unsigned OFS_W       = 10,
   parameter bit          USE_SUB_CMP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmp_valid_i,
   input  logic [DATA_W-1:0]     cmp_lhs_i,
   input  logic [DATA_W-1:0]     cmp_rhs_i,
   input  logic                  br_valid_i,
   input  logic [INSN_W-1:0]     br_insn_i,
   input  logic [ADDR_W-1:0]     br_addr_i,
   output logic [REL_FLAG_N-1:0] flags_o,
   output logic                  br_taken_o,
   output logic [ADDR_W-1:0]     br_next_o,
   output logic                  br_illegal_o
);
   rel_flags_t rel_now;
   rel_flags_t flags_held;

   cbu_relation #(
      .DATA_W      (DATA_W),
      .USE_SUB_CMP (USE_SUB_CMP)
   ) u_relation (
      .lhs_i (cmp_lhs_i),
      .rhs_i (cmp_rhs_i),
      .rel_o (rel_now)
   );

   cbu_flag_reg #(
      .DATA_W (DATA_W)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (cmp_valid_i),
      .rel_i   (rel_now),
      .lhs_i   (cmp_lhs_i),
      .rhs_i   (cmp_rhs_i),
      .flags_o (flags_held)
   );

   // R11: branch sees the registered flags only
   cbu_branch_eval #(
      .ADDR_W (ADDR_W),
      .INSN_W (INSN_W),
      .OFS_W  (OFS_W)
   ) u_branch (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (br_valid_i),
      .insn_i    (br_insn_i),
      .addr_i    (br_addr_i),
      .flags_i   (flags_held),
      .taken_o   (br_taken_o),
      .next_o    (br_next_o),
      .illegal_o (br_illegal_o)
   );

   assign flags_o = flags_held;

endmodule

// File: tb/cmp_branch_unit_tb_top.sv
module cmp_branch_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_valid_i = 1'b0;
   logic [31:0] cmp_lhs_i = '0;
   logic [31:0] cmp_rhs_i = '0;
   logic        br_valid_i = 1'b0;
   logic [15:0] br_insn_i = '0;
   logic [31:0] br_addr_i = '0;
   logic [4:0]  flags_o;
   logic        br_taken_o;
   logic [31:0] br_next_o;
   logic        br_illegal_o;

   always #5 clk = ~clk;

   cmp_branch_unit dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmp_valid_i  (cmp_valid_i),
      .cmp_lhs_i    (cmp_lhs_i),
      .cmp_rhs_i    (cmp_rhs_i),
      .br_valid_i   (br_valid_i),
      .br_insn_i    (br_insn_i),
      .br_addr_i    (br_addr_i),
      .flags_o      (flags_o),
      .br_taken_o   (br_taken_o),
      .br_next_o    (br_next_o),
      .br_illegal_o (br_illegal_o)
   );

   // what: 0 flags, 1 taken, 2 next, 3 illegal
   typedef struct {
      int          due;
      int          what;
      logic [31:0] exp;
      string       req;
   } sb_item_t;

   sb_item_t    sbq[$];
   int          cyc = 0;
   int          n_checks = 0;
   int          n_errors = 0;
   logic [4:0]  mdl_flags = '0;
   bit          done = 1'b0;

   always @(negedge clk) cyc = cyc + 1;

   function automatic logic [4:0] ref_rel(input logic [31:0] a, input logic [31:0] b);
      logic [4:0] f;
      f[0] = (a == b);
      f[1] = ($signed(a) < $signed(b));
      f[2] = ($signed(a) > $signed(b));
      f[3] = (a < b);
      f[4] = (a > b);
      return f;
   endfunction

   function automatic logic ref_cond(input int c, input logic [4:0] f);
      case (c)
         0: return f[0];
         1: return !f[0];
         2: return f[1];
         3: return f[2];
         4: return f[3];
         5: return f[4];
         6: return f[2] | f[0];
         7: return f[1] | f[0];
         8: return f[4] | f[0];
         9: return f[3] | f[0];
         default: return 1'b0;
      endcase
   endfunction

   task automatic push(input int due, input int what, input logic [31:0] exp, input string req);
      sb_item_t it;
      it.due = due; it.what = what; it.exp = exp; it.req = req;
      sbq.push_back(it);
   endtask

   task automatic push_branch(input logic [15:0] insn, input logic [31:0] addr,
                              input logic [4:0] f, input string req);
      logic        isb;
      int          c;
      logic        tk;
      logic        il;
      logic [31:0] disp;
      isb  = insn[15] && insn[14];
      c    = int'(insn[13:10]);
      tk   = isb && (c < 10) && ref_cond(c, f);
      il   = isb && (c >= 10);
      disp = {{21{insn[9]}}, insn[9:0], 1'b0};
      push(cyc, 1, {31'd0, tk}, req);
      push(cyc, 2, tk ? addr + disp : addr + 32'd2, req);
      push(cyc, 3, {31'd0, il}, req);
   endtask

   task automatic drive(input logic cv, input logic [31:0] a, input logic [31:0] b,
                        input logic bv, input logic [15:0] insn, input logic [31:0] addr,
                        input string req);
      @(negedge clk);
      #1;
      cmp_valid_i = cv; cmp_lhs_i = a; cmp_rhs_i = b;
      br_valid_i = bv; br_insn_i = insn; br_addr_i = addr;
      if (bv) push_branch(insn, addr, mdl_flags, req);
      if (cv) begin
         mdl_flags = ref_rel(a, b);
         push(cyc + 1, 0, {27'd0, mdl_flags}, req);
      end
   endtask

   task automatic do_cmp(input logic [31:0] a, input logic [31:0] b, input string req);
      drive(1'b1, a, b, 1'b0, 16'h0, 32'h0, req);
   endtask

   task automatic do_br(input logic [15:0] insn, input logic [31:0] addr, input string req);
      drive(1'b0, $urandom, $urandom, 1'b1, insn, addr, req);
   endtask

   task automatic sweep(input logic [31:0] addr, input logic [9:0] ofs);
      for (int c = 0; c < 16; c++) begin
         do_br({2'b11, 4'(c), ofs}, addr, (c < 10) ? "R7" : "R8");
      end
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            sb_item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.what)
               0: act = {27'd0, flags_o};
               1: act = {31'd0, br_taken_o};
               2: act = br_next_o;
               default: act = {31'd0, br_illegal_o};
            endcase
            n_checks++;
            if (it.due != cyc || act !== it.exp) begin
               n_errors++;
               $display("FAIL %s item %0d cycle %0d: actual %h expected %h",
                        it.req, it.what, cyc, act, it.exp);
            end
         end
      end
   end

   // watchdog
   initial begin
      #(150000 * 10);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   logic [31:0] bnd [4] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      // R1: reset value
      push(cyc + 1, 0, 32'h0, "R1");
      @(negedge clk);
      // R7 with cleared flags: only not-equal taken
      sweep(32'h0000_1000, 10'h004);
      // R2 R3 R4: boundary pairs
      for (int i = 0; i < 4; i++) begin
         for (int j = 0; j < 4; j++) begin
            do_cmp(bnd[i], bnd[j], (i == j) ? "R2" : "R3_R4");
            sweep(32'h0000_2000 + 32'(i * 64 + j * 4), 10'(i * 37 + j));
         end
      end
      // random pairs, some equal
      for (int k = 0; k < 120; k++) begin
         logic [31:0] a;
         logic [31:0] b;
         a = $urandom;
         b = (k % 7 == 0) ? a : ((k % 3 == 0) ? (a ^ 32'h8000_0000) : $urandom);
         do_cmp(a, b, "R3_R4");
         do_br({2'b11, 4'(k % 16), 10'($urandom)}, $urandom & 32'hFFFF_FFFE, "R7");
      end
      // R5: idle cycles with moving operands
      do_cmp(32'd5, 32'd9, "R4");
      drive(1'b0, 32'd9, 32'd5, 1'b0, 16'h0, 32'h0, "R5");
      drive(1'b0, 32'd7, 32'd7, 1'b0, 16'h0, 32'h0, "R5");
      push(cyc, 0, {27'd0, mdl_flags}, "R5");
      // R9: offset extremes with equal flags
      do_cmp(32'd3, 32'd3, "R2");
      do_br({2'b11, 4'd0, 10'h1FF}, 32'h0000_4000, "R9");
      do_br({2'b11, 4'd0, 10'h200}, 32'h0000_4000, "R9");
      do_br({2'b11, 4'd0, 10'h3FF}, 32'h0000_4000, "R9");
      do_br({2'b11, 4'd0, 10'h000}, 32'h0000_4000, "R9");
      do_br({2'b11, 4'd0, 10'h001}, 32'hFFFF_FFFE, "R9");
      // R10: not taken and wrap
      do_br({2'b11, 4'd1, 10'h010}, 32'hFFFF_FFFE, "R10");
      do_br({2'b11, 4'd2, 10'h010}, 32'h0000_0100, "R10");
      // R8: unassigned codes at non-zero offset
      do_br({2'b11, 4'd10, 10'h1FF}, 32'h0000_0200, "R8");
      do_br({2'b11, 4'd15, 10'h200}, 32'h0000_0200, "R8");
      // R6: words outside the branch form, and branch_valid low
      do_br({2'b10, 4'd0, 10'h020}, 32'h0000_0300, "R6");
      do_br({2'b01, 4'd0, 10'h020}, 32'h0000_0300, "R6");
      do_br({2'b00, 4'd12, 10'h020}, 32'h0000_0300, "R6");
      drive(1'b0, 32'h0, 32'h0, 1'b0, {2'b11, 4'd0, 10'h020}, 32'h0000_0300, "R6");
      push_branch(16'h0, 32'h0000_0300, mdl_flags, "R6");
      // R11: compare and branch in one cycle, flags now equal
      drive(1'b1, 32'd1, 32'd2, 1'b1, {2'b11, 4'd0, 10'h008}, 32'h0000_0500, "R11");
      do_br({2'b11, 4'd0, 10'h008}, 32'h0000_0500, "R11");
      do_br({2'b11, 4'd4, 10'h008}, 32'h0000_0500, "R11");
      drive(1'b0, 32'h0, 32'h0, 1'b0, 16'h0, 32'h0, "idle");
      repeat (3) @(negedge clk);
      n_checks++;
      if (sbq.size() != 0) begin
         n_errors++;
         $display("FAIL scoreboard: actual %0d left expected 0", sbq.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule